// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, that share a data width. Each side owns a storage register with its own capture clock. The A register samples the A bus on each rising edge of `clk_ab`. The B register samples the B bus on each rising edge of `clk_ba`. Capture ignores every output control, so either register can be loaded while the block drives nothing at all.

Two controls pick which side is driven. The active-low `oe_n` isolates both buses when it is high. When it is low, `dir` picks the driven side: `dir` high drives B and `dir` low drives A. Each transfer direction has its own select. A low select passes the live opposite bus straight through with no clock. A high select passes the stored register of the opposite side. When a register is clocked in stored mode, the driven bus takes the new contents right after that edge.

Each bus appears as three ports: an input, an output and an output enable. A wrapper can merge them into tri-state pins. The registers clear on a clock edge while `rst` is high.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high, a rising edge of `clk_ab` clears the A register and a rising edge of `clk_ba` clears the B register. Reading either register in stored mode then gives all zeros.
- R2: On every rising edge of `clk_ab` with `rst` low, the A register loads `a_in`, whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R3: On every rising edge of `clk_ba` with `rst` low, the B register loads `b_in`, whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R4: When `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: When `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. `a_oe` and `b_oe` are never 1 together.
- R6: When B is driven and `sel_ab`=0, `b_out` equals `a_in` and follows changes on `a_in` with no clock edge.
- R7: When B is driven and `sel_ab`=1, `b_out` equals the A register.
- R8: When A is driven and `sel_ba`=0, `a_out` equals `b_in` and follows changes on `b_in` with no clock edge.
- R9: When A is driven and `sel_ba`=1, `a_out` equals the B register.
- R10: In stored mode, a rising edge of the register's clock both loads the register and updates the driven output. After the edge, the output shows the newly captured bus value.
- R11: Whenever a side's output enable is 0, that side's output (`a_out` or `b_out`) is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A register |
| clk_ba | input | 1 | Capture clock of the B register |
| rst | input | 1 | Synchronous active-high register clear |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | A-to-B source: 0 live `a_in`, 1 A register |
| sel_ba | input | 1 | B-to-A source: 0 live `b_in`, 1 B register |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value driven onto the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value driven onto the B bus |
| b_oe | output | 1 | B bus drive enable |

## Verification
On every clock edge, the assertions check that the two enables are never active together and that isolation turns both off. They also check that each register holds the bus value from its previous edge, that each driven output matches the live bus or the register as its select asks, and that an undriven output is zero. Only the bench scenarios can show a live output following its input with no clock edge, and a register loaded during isolation later appearing in stored mode. The same holds for the full sweep of enable, direction and select settings against a reference model, and for the same-edge load-and-drive case.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_B    = 2'd1,
    DRV_A    = 2'd2
  } drive_e;

  localparam int PATHS = 2;
  localparam int P_AB  = 0;
  localparam int P_BA  = 1;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e side,
  output logic   a_oe,
  output logic   b_oe
);
  always_comb begin
    if (oe_n)     side = DRV_NONE;
    else if (dir) side = DRV_B;
    else          side = DRV_A;
    a_oe = (side == DRV_A);
    b_oe = (side == DRV_B);
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             sel_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    if (!en)            out = '0;
    else if (sel_stored) out = stored;
    else                out = live;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  drive_e           side;

  logic             cap_clk [PATHS];
  logic [WIDTH-1:0] cap_d   [PATHS];
  logic [WIDTH-1:0] cap_q   [PATHS];
  logic             p_en    [PATHS];
  logic             p_sel   [PATHS];
  logic [WIDTH-1:0] p_out   [PATHS];

  xcvr_drive_decode u_dec (
    .oe_n (oe_n),
    .dir  (dir),
    .side (side),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  always_comb begin
    cap_clk[P_AB] = clk_ab;
    cap_clk[P_BA] = clk_ba;
    cap_d[P_AB]   = a_in;
    cap_d[P_BA]   = b_in;
    p_en[P_AB]    = b_oe;
    p_en[P_BA]    = a_oe;
    p_sel[P_AB]   = sel_ab;
    p_sel[P_BA]   = sel_ba;
  end

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    xcvr_capture #(.WIDTH(WIDTH)) u_reg (
      .clk (cap_clk[p]),
      .rst (rst),
      .d   (cap_d[p]),
      .q   (cap_q[p])
    );
    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
      .en         (p_en[p]),
      .sel_stored (p_sel[p]),
      .live       (cap_d[p]),
      .stored     (cap_q[p]),
      .out        (p_out[p])
    );
  end

  assign a_q   = cap_q[P_AB];
  assign b_q   = cap_q[P_BA];
  assign b_out = p_out[P_AB];
  assign a_out = p_out[P_BA];
endmodule

// File: rtl/xcvr_reg_checker.sv
module xcvr_reg_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             a_oe,
  input logic             b_oe,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q
);
  AST_OE_EXCLUSIVE: assert property (@(posedge clk_ab) disable iff (rst) !(a_oe && b_oe)); // R5
  AST_DIR_SELECT: assert property (@(posedge clk_ab) disable iff (rst) !oe_n |-> (b_oe == dir && a_oe == !dir)); // R5
  AST_ISOLATE: assert property (@(posedge clk_ba) disable iff (rst) oe_n |-> (!a_oe && !b_oe)); // R4
  AST_A_CAPTURE: assert property (@(posedge clk_ab) disable iff (rst) 1'b1 |=> (a_q == $past(a_in))); // R2
  AST_B_CAPTURE: assert property (@(posedge clk_ba) disable iff (rst) 1'b1 |=> (b_q == $past(b_in))); // R3
  AST_B_LIVE: assert property (@(posedge clk_ab) disable iff (rst) (b_oe && !sel_ab) |-> (b_out == a_in)); // R6
  AST_B_STORED: assert property (@(posedge clk_ab) disable iff (rst) (b_oe && sel_ab) |-> (b_out == a_q)); // R7
  AST_A_LIVE: assert property (@(posedge clk_ba) disable iff (rst) (a_oe && !sel_ba) |-> (a_out == b_in)); // R8
  AST_A_STORED: assert property (@(posedge clk_ba) disable iff (rst) (a_oe && sel_ba) |-> (a_out == b_q)); // R9
  AST_A_IDLE_ZERO: assert property (@(posedge clk_ba) disable iff (rst) !a_oe |-> (a_out == '0)); // R11
  AST_B_IDLE_ZERO: assert property (@(posedge clk_ab) disable iff (rst) !b_oe |-> (b_out == '0)); // R11
endmodule

bind bus_xcvr_reg xcvr_reg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_ab (clk_ab),
  .clk_ba (clk_ba),
  .rst    (rst),
  .oe_n   (oe_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .b_out  (b_out),
  .a_oe   (a_oe),
  .b_oe   (b_oe),
  .a_q    (a_q),
  .b_q    (b_q)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk_ab = 0, clk_ba = 0, rst = 1;
  logic oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  logic [W-1:0] ma = '0, mb = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  bus_xcvr_reg #(.WIDTH(W)) uut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pulse_ab();
    #(CLK_PERIOD/2) clk_ab = 1;
    if (rst) ma = '0; else ma = a_in;
    #(CLK_PERIOD/2) clk_ab = 0;
    #1;
  endtask

  task automatic pulse_ba();
    #(CLK_PERIOD/2) clk_ba = 1;
    if (rst) mb = '0; else mb = b_in;
    #(CLK_PERIOD/2) clk_ba = 0;
    #1;
  endtask

  task automatic set_ctl(input logic n, input logic d, input logic s1, input logic s2);
    oe_n = n; dir = d; sel_ab = s1; sel_ba = s2;
    #1;
  endtask

  task automatic check_model(input string req);
    logic eb, ea;
    logic [W-1:0] xb, xa;
    eb = !oe_n && dir;
    ea = !oe_n && !dir;
    xb = eb ? (sel_ab ? ma : a_in) : '0;
    xa = ea ? (sel_ba ? mb : b_in) : '0;
    chk({req, " b_oe"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eb});
    chk({req, " a_oe"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ea});
    chk({req, " b_out"}, b_out, xb);
    chk({req, " a_out"}, a_out, xa);
  endtask

  task automatic t_reset();
    rst = 1; a_in = 8'hA5; b_in = 8'h5A;
    pulse_ab(); pulse_ba();
    set_ctl(0, 1, 1, 0);
    chk("R1 A reg cleared", b_out, 8'h00);
    set_ctl(0, 0, 0, 1);
    chk("R1 B reg cleared", a_out, 8'h00);
    rst = 0; #1;
  endtask

  task automatic t_isolation();
    set_ctl(1, 1, 1, 1);
    a_in = 8'h3C; b_in = 8'hC3; #1;
    check_model("R4 R11 isolated");
    pulse_ab(); pulse_ba();
    check_model("R4 isolated after clocks");
    set_ctl(0, 1, 1, 0);
    chk("R2 capture while isolated", b_out, 8'h3C);
    set_ctl(0, 0, 0, 1);
    chk("R3 capture while isolated", a_out, 8'hC3);
  endtask

  task automatic t_live_ab();
    set_ctl(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      a_in = W'($urandom); #1;
      chk("R6 live A to B", b_out, a_in);
      chk("R11 A side undriven", a_out, 8'h00);
    end
  endtask

  task automatic t_live_ba();
    set_ctl(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      b_in = W'($urandom); #1;
      chk("R8 live B to A", a_out, b_in);
      chk("R11 B side undriven", b_out, 8'h00);
    end
  endtask

  task automatic t_stored_ab();
    set_ctl(0, 0, 1, 0);
    a_in = 8'h77; pulse_ab();
    set_ctl(0, 1, 1, 1);
    a_in = 8'h11; #1;
    chk("R7 stored A to B", b_out, 8'h77);
  endtask

  task automatic t_stored_ba();
    set_ctl(0, 1, 0, 0);
    b_in = 8'h99; pulse_ba();
    set_ctl(0, 0, 0, 1);
    b_in = 8'h22; #1;
    chk("R9 stored B to A", a_out, 8'h99);
  endtask

  task automatic t_load_drive();
    set_ctl(0, 1, 1, 0);
    a_in = 8'hE1; pulse_ab();
    chk("R10 A load and drive", b_out, 8'hE1);
    set_ctl(0, 0, 0, 1);
    b_in = 8'h1E; pulse_ba();
    chk("R10 B load and drive", a_out, 8'h1E);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 16; c++) begin
      set_ctl(c[3], c[2], c[1], c[0]);
      a_in = W'($urandom); b_in = W'($urandom); #1;
      check_model("R5 sweep live");
      if (c[0]) pulse_ab(); else pulse_ba();
      a_in = W'($urandom); b_in = W'($urandom); #1;
      check_model("R5 sweep after edge");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_isolation();
    t_live_ab();
    t_live_ba();
    t_stored_ab();
    t_stored_ba();
    t_load_drive();
    t_sweep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule